// File: doc/BRIEF.md
# Command-Driven SHA-256 Compression Engine

This block computes SHA-256 over a message that the host has already padded and cut into 512-bit blocks. The host drives a 2-bit opcode with a 512-bit block beside it. One opcode begins a new hash from the standard initial value. Another folds a further block into the running chaining value. A third asks for the current 256-bit digest. Every cycle yields a response: either a digest tagged valid, or an all-zero "no data" response.

A block command starts 64 rounds, one per clock. During those rounds the engine drops `cmd_ready` and raises `busy`. The command port works as a valid/ready stream: a non-idle opcode is the valid, and it is taken only in a cycle where `cmd_ready` is high. A command presented while `cmd_ready` is low is dropped and is not held over, so the host must keep it on the port until it sees ready. The response stream has no back-pressure. A digest response stays valid for exactly one cycle and the host must capture it then.

Top module: `hash256_engine`

## Requirements
- R1: Opcode 01 (start) sets the chaining value to the SHA-256 initial hash before compressing the block. The digest of the one-block padded message "abc" is ba7816bf...f20015ad.
- R2: Opcode 10 (continue) compresses the block on top of the current chaining value. The two-block 448-bit standard vector gives 85e655d6...f20e533a after block one and 248d6a61...19db06c1 after block two.
- R3: After a start or continue is accepted, `busy` is high and `cmd_ready` is low for exactly 64 cycles. The new digest is in place when `busy` falls.
- R4: Any opcode presented while `cmd_ready` is low has no effect on the digest that is later read back.
- R5: An accepted opcode 11 (query) gives `rsp_valid` high in the next cycle only, with H0 in `rsp_digest[255:224]` down to H7 in `rsp_digest[31:0]`.
- R6: Whenever `rsp_valid` is low, `rsp_digest` is all zeros.
- R7: Opcode 00 is idle. It changes no state, whatever `cmd_block` carries.
- R8: After reset, `busy` and `rsp_valid` are low, `cmd_ready` is high, and a query returns the initial hash 6a09e667...5be0cd19.
- R9: A query accepted in the first cycle after `busy` falls returns the digest that includes the block just compressed.
- R10: Block word 0 is `cmd_block[511:480]` and word 15 is `cmd_block[31:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | 00 idle, 01 start, 10 continue, 11 query |
| cmd_block | input | 512 | Sixteen 32-bit message words, word 0 in the top bits |
| cmd_ready | output | 1 | A non-idle opcode is accepted in this cycle |
| busy | output | 1 | Rounds are in progress |
| rsp_valid | output | 1 | `rsp_digest` carries a digest |
| rsp_digest | output | 256 | H0..H7, H0 in the top bits; zero when not valid |

## Verification
Two events can fall in adjacent cycles. One is the final add, which writes the new digest at the edge where `busy` falls. The other is the query readout, which samples the digest at the very next edge. The bench provokes this by issuing the query as soon as `cmd_ready` returns after the last block, and it judges the result against the published final digest. A second overlap occurs while rounds are running: a start and a continue are presented to the port at that time. The scoreboard then checks that the digest read back afterwards is exactly the block-one value, unaffected by the intruding commands.

// File: rtl/hash256_pkg.sv
`timescale 1ns/1ps
package hash256_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 16;
  localparam int HWORDS  = 8;
  localparam int ROUNDS  = 64;
  localparam int BLOCK_W = WORD_W * NWORDS;
  localparam int DIGEST_W = WORD_W * HWORDS;
  localparam int RND_W   = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_START = 2'b01,
    OP_CONT  = 2'b10,
    OP_QUERY = 2'b11
  } op_e;

  typedef struct packed {
    word_t a; word_t b; word_t c; word_t d;
    word_t e; word_t f; word_t g; word_t h;
  } vars_t;

  localparam word_t KTAB [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam vars_t IV = '{
    a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
    e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
  };

  function automatic word_t rotr(word_t x, int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t small_s0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t small_s1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic vars_t add_vars(vars_t x, vars_t y);
    vars_t r;
    r.a = x.a + y.a; r.b = x.b + y.b; r.c = x.c + y.c; r.d = x.d + y.d;
    r.e = x.e + y.e; r.f = x.f + y.f; r.g = x.g + y.g; r.h = x.h + y.h;
    return r;
  endfunction
endpackage

// File: rtl/hash256_sched.sv
`timescale 1ns/1ps
module hash256_sched
  import hash256_pkg::*;
(
  input  logic               clk,
  input  logic               load,
  input  logic               step,
  input  logic [BLOCK_W-1:0] block,
  output word_t              w_cur
);
  word_t win [NWORDS];
  word_t blk_w [NWORDS];
  word_t w_new;

  for (genvar i = 0; i < NWORDS; i++) begin : g_split
    assign blk_w[i] = block[BLOCK_W-1-WORD_W*i -: WORD_W];
  end

  assign w_cur = win[0];
  assign w_new = small_s1(win[NWORDS-2]) + win[NWORDS-7] + small_s0(win[1]) + win[0];

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NWORDS; i++) win[i] <= blk_w[i];
    end else if (step) begin
      for (int i = 0; i < NWORDS-1; i++) win[i] <= win[i+1];
      win[NWORDS-1] <= w_new;
    end
  end
endmodule

// File: rtl/hash256_round.sv
`timescale 1ns/1ps
module hash256_round
  import hash256_pkg::*;
(
  input  vars_t v_in,
  input  word_t k,
  input  word_t w,
  output vars_t v_out
);
  word_t t1, t2, ch, maj;

  always_comb begin
    ch    = (v_in.e & v_in.f) ^ (~v_in.e & v_in.g);
    maj   = (v_in.a & v_in.b) ^ (v_in.a & v_in.c) ^ (v_in.b & v_in.c);
    t1    = v_in.h + big_s1(v_in.e) + ch + k + w;
    t2    = big_s0(v_in.a) + maj;
    v_out = '{a: t1 + t2, b: v_in.a, c: v_in.b, d: v_in.c,
              e: v_in.d + t1, f: v_in.e, g: v_in.f, h: v_in.g};
  end
endmodule

// File: rtl/hash256_ctrl.sv
`timescale 1ns/1ps
module hash256_ctrl
  import hash256_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_op,
  output logic             cmd_ready,
  output logic             ld_start,
  output logic             ld_cont,
  output logic             qry,
  output logic             step,
  output logic             last,
  output logic             busy,
  output logic [RND_W-1:0] rnd
);
  logic busy_q;

  assign busy      = busy_q;
  assign cmd_ready = !busy_q;
  assign ld_start  = cmd_ready && (cmd_op == OP_START);
  assign ld_cont   = cmd_ready && (cmd_op == OP_CONT);
  assign qry       = cmd_ready && (cmd_op == OP_QUERY);
  assign step      = busy_q;
  assign last      = busy_q && (rnd == RND_W'(ROUNDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rnd    <= '0;
    end else if (ld_start || ld_cont) begin
      busy_q <= 1'b1;
      rnd    <= '0;
    end else if (busy_q) begin
      rnd <= rnd + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  // R3: a block command raises busy
  p_busy_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_start || ld_cont) |=> (busy && rnd == '0));
  // R3: rounds advance one per clock
  p_rnd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && rnd == $past(rnd) + 1'b1));
  // R3: busy ends after round 63
  p_busy_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
  // R4: nothing accepted while busy
  p_no_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(ld_start || ld_cont || qry));
endmodule

// File: rtl/hash256_engine.sv
`timescale 1ns/1ps
module hash256_engine
  import hash256_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cmd_op,
  input  logic [BLOCK_W-1:0]  cmd_block,
  output logic                cmd_ready,
  output logic                busy,
  output logic                rsp_valid,
  output logic [DIGEST_W-1:0] rsp_digest
);
  logic ld_start, ld_cont, qry, step, last;
  logic [RND_W-1:0] rnd;
  word_t w_cur;
  vars_t digest_q, mid_q, work_q, work_nx;

  hash256_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .ld_start(ld_start), .ld_cont(ld_cont), .qry(qry), .step(step),
    .last(last), .busy(busy), .rnd(rnd)
  );

  hash256_sched u_sched (
    .clk(clk), .load(ld_start || ld_cont), .step(step),
    .block(cmd_block), .w_cur(w_cur)
  );

  hash256_round u_round (
    .v_in(work_q), .k(KTAB[rnd]), .w(w_cur), .v_out(work_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digest_q   <= IV;
      mid_q      <= IV;
      work_q     <= IV;
      rsp_valid  <= 1'b0;
      rsp_digest <= '0;
    end else begin
      if (ld_start) begin
        digest_q <= IV;
        mid_q    <= IV;
        work_q   <= IV;
      end else if (ld_cont) begin
        mid_q  <= digest_q;
        work_q <= digest_q;
      end else if (step) begin
        work_q <= work_nx;
        if (last) digest_q <= add_vars(mid_q, work_nx);
      end
      rsp_valid  <= qry;
      rsp_digest <= qry ? digest_q : '0;
    end
  end

  // R2: continue saves the chaining value
  p_mid_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cont |=> (mid_q == $past(digest_q)));
  // R4: digest frozen through rounds before the final add
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(digest_q));
  // R5: query answered in the next cycle
  p_rsp_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qry |=> (rsp_valid && rsp_digest == $past(digest_q)));
  // R5: response lasts a single cycle unless re-queried
  p_rsp_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(qry)) |-> 1'b0);
  // R6: quiet response is zero
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_digest == '0));
endmodule

// File: tb/hash256_engine_tb_top.sv
`timescale 1ns/1ps
module hash256_engine_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cmd_op = 2'b00;
  logic [511:0] cmd_block = '0;
  logic         cmd_ready, busy, rsp_valid;
  logic [255:0] rsp_digest;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [255:0] exp_q [$];
  string        tag_q [$];

  localparam logic [255:0] D_IV   = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [255:0] D_ABC  = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] D_MID1 = 256'h85e655d6417a17953363376a624cde5c76e09589cac5f811cc4b32c1f20e533a;
  localparam logic [255:0] D_TWO  = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

  localparam logic [511:0] B_ABC = {32'h61626380, {14{32'h0}}, 32'h00000018};
  localparam logic [511:0] B_V1 = {
    32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
    32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
    32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
    32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
  localparam logic [511:0] B_V2 = {{14{32'h0}}, 32'h00000000, 32'h000001c0};

  hash256_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_block(cmd_block),
    .cmd_ready(cmd_ready), .busy(busy), .rsp_valid(rsp_valid), .rsp_digest(rsp_digest)
  );

  always #10 clk = ~clk;

  task automatic check(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: wait for ready, present one command for one cycle
  task automatic send(logic [1:0] op, logic [511:0] blk);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op;
    cmd_block = blk;
    @(negedge clk);
    cmd_op = 2'b00;
  endtask

  task automatic query(logic [255:0] exp, string tag);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = 2'b11;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_op = 2'b00;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // monitor: scoreboard pop on every valid response
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected response", rsp_digest, '0);
        end else begin
          logic [255:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_digest === e, t, rsp_digest, e);
        end
      end else if (rsp_digest !== '0) begin
        check(1'b0, "R6 nonzero idle response", rsp_digest, '0);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(busy === 1'b0 && cmd_ready === 1'b1 && rsp_valid === 1'b0, "R8 reset flags",
          {253'b0, busy, cmd_ready, rsp_valid}, {253'b0, 3'b010});
    query(D_IV, "R8 digest after reset");

    // R7 idle with junk data
    cmd_block = B_ABC;
    repeat (4) @(negedge clk);
    check(busy === 1'b0, "R7 idle stays not busy", {255'b0, busy}, '0);
    query(D_IV, "R7 idle leaves digest");

    // R1 / R10 one-block abc, R3 busy length
    send(2'b01, B_ABC);
    cnt = 0;
    while (busy) begin
      if (cmd_ready) check(1'b0, "R3 ready while busy", 256'd1, 256'd0);
      cnt++;
      @(negedge clk);
    end
    check(cnt == 64, "R3 busy cycles", 256'(cnt), 256'd64);
    query(D_ABC, "R1 R10 abc digest");

    // R4 commands during rounds ignored; R1 start resets chaining
    send(2'b01, B_V1);
    repeat (5) @(negedge clk);
    check(cmd_ready === 1'b0, "R4 port not ready mid-rounds", {255'b0, cmd_ready}, '0);
    cmd_op = 2'b01; cmd_block = B_ABC;
    @(negedge clk);
    cmd_op = 2'b10;
    @(negedge clk);
    cmd_op = 2'b11;
    @(negedge clk);
    cmd_op = 2'b00;
    wait_idle();
    query(D_MID1, "R4 R2 block one digest");

    // R2 continue, R9 query right after busy falls
    send(2'b10, B_V2);
    wait_idle();
    cmd_op = 2'b11;
    exp_q.push_back(D_TWO);
    tag_q.push_back("R9 R2 two-block digest at first ready cycle");
    @(negedge clk);
    cmd_op = 2'b00;

    // R5 back-to-back queries give two single-cycle responses
    @(negedge clk);
    cmd_op = 2'b11;
    exp_q.push_back(D_TWO); tag_q.push_back("R5 query one");
    @(negedge clk);
    exp_q.push_back(D_TWO); tag_q.push_back("R5 query two");
    @(negedge clk);
    cmd_op = 2'b00;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R5 response ends", {255'b0, rsp_valid}, '0);

    // R1 start again discards chaining value
    send(2'b01, B_ABC);
    wait_idle();
    query(D_ABC, "R1 restart abc digest");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all responses seen", 256'(exp_q.size()), '0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule